// File: doc/BRIEF.md
# Serial Interface Interrupt Flag Unit

This block holds the status flags of a serial controller that runs either as a two-wire bus master/slave (I2C mode) or as a clocked synchronous shifter. An external shift/bus engine reports what happened through single-cycle event pulses: a byte moved from the transmit buffer into the shifter, the shifter finished a byte, a byte was received, a stop condition was seen, the peer did not acknowledge, or arbitration was lost. The unit turns those pulses into sticky flags. It clears the data flags in hardware when the CPU touches a data register. Software clears the event flags with a read-then-clear handshake.

Each flag is ANDed with its own enable to form one of five request lines. The not-acknowledged and arbitration-lost/overrun flags share a single request. A combined CPU request is raised when any request is active and the global mask input is low. Flags and requests are registered and change together, one clock edge after the input that caused the change.

Top module: `serif_irq_unit`

## Requirements
- R1: After a synchronous reset, flag_txe is 1, the other five flags are 0, and all request outputs, including cpu_irq, are 0.
- R2: A tx_wr pulse clears flag_txe. An ev_load pulse sets it. When both arrive in the same cycle, flag_txe ends up 1.
- R3: ev_txdone sets flag_tend only if flag_txe is 1 in that cycle. A tx_wr pulse clears flag_tend. If both arrive in the same cycle, flag_tend ends up 1.
- R4: ev_rxbyte sets flag_rxf and rx_rd clears it. If both arrive in the same cycle, flag_rxf ends up 1.
- R5: With mode_i2c=0, ev_rxbyte while flag_rxf is 1 and rx_rd is 0 sets flag_al, and flag_rxf stays 1. With mode_i2c=1 the same stimulus leaves flag_al unchanged. ev_al sets flag_al in either mode.
- R6: clr_stop, clr_nack and clr_al each clear their flag only after a stat_rd pulse has seen that flag as 1. A clear strobe with no such earlier read is ignored. A set event in the same cycle as an accepted clear leaves the flag at 1.
- R7: irq_txe, irq_tend and irq_rxf each equal their flag ANDed with their enable (ie_txe, ie_tend, ie_rxf). They update on the same edge as the flag.
- R8: irq_nak equals ie_nak AND (flag_al OR (flag_nack AND mode_i2c)).
- R9: With mode_i2c=0, ev_stop and ev_nack are ignored and irq_stop stays 0. With mode_i2c=1, irq_stop equals flag_stop AND ie_stop.
- R10: cpu_irq is 1 exactly when at least one request output is 1 and irq_mask is 0, both taken on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i2c | input | 1 | 1 = I2C mode, 0 = clocked synchronous mode |
| ie_txe | input | 1 | Transmit-empty request enable |
| ie_tend | input | 1 | Transmit-end request enable |
| ie_rxf | input | 1 | Receive-full request enable |
| ie_stop | input | 1 | Stop-detected request enable |
| ie_nak | input | 1 | NACK / arbitration-lost / overrun request enable |
| irq_mask | input | 1 | Global CPU interrupt mask, 1 = masked |
| tx_wr | input | 1 | CPU write to the transmit data register |
| rx_rd | input | 1 | CPU read of the receive data register |
| stat_rd | input | 1 | CPU read of the status flags (arms clears) |
| clr_stop | input | 1 | Software clear strobe for flag_stop |
| clr_nack | input | 1 | Software clear strobe for flag_nack |
| clr_al | input | 1 | Software clear strobe for flag_al |
| ev_load | input | 1 | Engine: transmit byte moved into the shifter |
| ev_txdone | input | 1 | Engine: shifter finished a byte |
| ev_rxbyte | input | 1 | Engine: a byte was received |
| ev_stop | input | 1 | Engine: stop condition detected |
| ev_nack | input | 1 | Engine: no acknowledge received |
| ev_al | input | 1 | Engine: arbitration lost |
| flag_txe | output | 1 | Transmit buffer empty flag |
| flag_tend | output | 1 | Transmit end flag |
| flag_rxf | output | 1 | Receive buffer full flag |
| flag_stop | output | 1 | Stop detected flag |
| flag_nack | output | 1 | NACK received flag |
| flag_al | output | 1 | Arbitration lost / overrun flag |
| irq_txe | output | 1 | Transmit-empty request |
| irq_tend | output | 1 | Transmit-end request |
| irq_rxf | output | 1 | Receive-full request |
| irq_stop | output | 1 | Stop-detected request |
| irq_nak | output | 1 | Merged NACK / arbitration / overrun request |
| cpu_irq | output | 1 | Masked combined request to the CPU |

## Verification
The bench drives every event, access strobe and enable with random traffic, so set and clear pulses often land in the same cycle. A design that let the clear win there would drop a reload of the transmit-empty flag and send a stale extra byte. It would also lose a received byte or a stop event. Switching between modes tests two things: that overrun is raised only in synchronous mode and keeps the receive-full flag, and that stop and NACK stay silent outside I2C mode. A design that got mode gating wrong would raise spurious requests in synchronous mode. Clear strobes also arrive with no earlier status read, and a design that honoured them would let software wipe an event it never saw.

// File: rtl/serif_irq_pkg.sv
package serif_irq_pkg;
  // Software-cleared (read-then-clear) flag slots
  localparam int NUM_STK  = 3;
  localparam int STK_STOP = 0;
  localparam int STK_NACK = 1;
  localparam int STK_AL   = 2;

  // Request line slots
  localparam int NUM_REQ  = 5;
  localparam int REQ_TXE  = 0;
  localparam int REQ_TEND = 1;
  localparam int REQ_RXF  = 2;
  localparam int REQ_STOP = 3;
  localparam int REQ_NAK  = 4;

  typedef logic [NUM_STK-1:0] stk_vec_t;
  typedef logic [NUM_REQ-1:0] req_vec_t;
endpackage

// File: rtl/serif_sticky_flag.sv
// One event flag with a read-then-clear handshake; set beats clear.
module serif_sticky_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic rd_i,
  input  logic clr_i,
  output logic flag_q,
  output logic flag_n
);
  logic armed_q;
  logic armed_n;
  logic clr_ok;

  always_comb begin
    clr_ok  = clr_i & armed_q;
    flag_n  = flag_q;
    if (clr_ok) flag_n = 1'b0;
    if (set_i)  flag_n = 1'b1;
    armed_n = (rd_i & flag_q) | (armed_q & ~clr_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= RST_VAL;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_n;
      armed_q <= armed_n;
    end
  end
endmodule

// File: rtl/serif_data_flags.sv
// Data-path flags cleared by register access and set by engine events.
module serif_data_flags #(
  parameter bit TXE_RST = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_i2c,
  input  logic tx_wr,
  input  logic rx_rd,
  input  logic ev_load,
  input  logic ev_txdone,
  input  logic ev_rxbyte,
  output logic txe_q,
  output logic tend_q,
  output logic rxf_q,
  output logic txe_n,
  output logic tend_n,
  output logic rxf_n,
  output logic ovr_o
);
  always_comb begin
    txe_n = txe_q;
    if (tx_wr)   txe_n = 1'b0;
    if (ev_load) txe_n = 1'b1;

    tend_n = tend_q;
    if (tx_wr)               tend_n = 1'b0;
    if (ev_txdone && txe_q)  tend_n = 1'b1;

    rxf_n = rxf_q;
    if (rx_rd)     rxf_n = 1'b0;
    if (ev_rxbyte) rxf_n = 1'b1;

    ovr_o = ~mode_i2c & ev_rxbyte & rxf_q & ~rx_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txe_q  <= TXE_RST;
      tend_q <= 1'b0;
      rxf_q  <= 1'b0;
    end else begin
      txe_q  <= txe_n;
      tend_q <= tend_n;
      rxf_q  <= rxf_n;
    end
  end
endmodule

// File: rtl/serif_req_gate.sv
// Enable gating, mode masking and the combined CPU request, all registered.
module serif_req_gate
  import serif_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     mode_i2c,
  input  logic     irq_mask,
  input  logic     txe_n,
  input  logic     tend_n,
  input  logic     rxf_n,
  input  stk_vec_t stk_n,
  input  req_vec_t ie,
  output req_vec_t req_q,
  output logic     cpu_q
);
  req_vec_t src;
  req_vec_t req_n;
  logic     cpu_n;

  always_comb begin
    src            = '0;
    src[REQ_TXE]   = txe_n;
    src[REQ_TEND]  = tend_n;
    src[REQ_RXF]   = rxf_n;
    src[REQ_STOP]  = stk_n[STK_STOP] & mode_i2c;
    src[REQ_NAK]   = stk_n[STK_AL] | (stk_n[STK_NACK] & mode_i2c);
  end

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_gate
    assign req_n[g] = src[g] & ie[g];
  end

  assign cpu_n = (|req_n) & ~irq_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
      cpu_q <= 1'b0;
    end else begin
      req_q <= req_n;
      cpu_q <= cpu_n;
    end
  end
endmodule

// File: rtl/serif_irq_unit.sv
module serif_irq_unit
  import serif_irq_pkg::*;
#(
  parameter bit TXE_RST = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_i2c,
  input  logic ie_txe,
  input  logic ie_tend,
  input  logic ie_rxf,
  input  logic ie_stop,
  input  logic ie_nak,
  input  logic irq_mask,
  input  logic tx_wr,
  input  logic rx_rd,
  input  logic stat_rd,
  input  logic clr_stop,
  input  logic clr_nack,
  input  logic clr_al,
  input  logic ev_load,
  input  logic ev_txdone,
  input  logic ev_rxbyte,
  input  logic ev_stop,
  input  logic ev_nack,
  input  logic ev_al,
  output logic flag_txe,
  output logic flag_tend,
  output logic flag_rxf,
  output logic flag_stop,
  output logic flag_nack,
  output logic flag_al,
  output logic irq_txe,
  output logic irq_tend,
  output logic irq_rxf,
  output logic irq_stop,
  output logic irq_nak,
  output logic cpu_irq
);
  logic     txe_n, tend_n, rxf_n, ovr;
  stk_vec_t stk_set, stk_clr, stk_q, stk_n;
  req_vec_t ie, req_q;

  serif_data_flags #(.TXE_RST(TXE_RST)) u_data (
    .clk(clk), .rst(rst), .mode_i2c(mode_i2c),
    .tx_wr(tx_wr), .rx_rd(rx_rd),
    .ev_load(ev_load), .ev_txdone(ev_txdone), .ev_rxbyte(ev_rxbyte),
    .txe_q(flag_txe), .tend_q(flag_tend), .rxf_q(flag_rxf),
    .txe_n(txe_n), .tend_n(tend_n), .rxf_n(rxf_n), .ovr_o(ovr)
  );

  always_comb begin
    stk_set           = '0;
    stk_set[STK_STOP] = ev_stop & mode_i2c;
    stk_set[STK_NACK] = ev_nack & mode_i2c;
    stk_set[STK_AL]   = ev_al | ovr;
    stk_clr           = '0;
    stk_clr[STK_STOP] = clr_stop;
    stk_clr[STK_NACK] = clr_nack;
    stk_clr[STK_AL]   = clr_al;
  end

  for (genvar g = 0; g < NUM_STK; g++) begin : g_stk
    serif_sticky_flag #(.RST_VAL(1'b0)) u_flag (
      .clk(clk), .rst(rst), .set_i(stk_set[g]), .rd_i(stat_rd),
      .clr_i(stk_clr[g]), .flag_q(stk_q[g]), .flag_n(stk_n[g])
    );
  end

  always_comb begin
    ie           = '0;
    ie[REQ_TXE]  = ie_txe;
    ie[REQ_TEND] = ie_tend;
    ie[REQ_RXF]  = ie_rxf;
    ie[REQ_STOP] = ie_stop;
    ie[REQ_NAK]  = ie_nak;
  end

  serif_req_gate u_gate (
    .clk(clk), .rst(rst), .mode_i2c(mode_i2c), .irq_mask(irq_mask),
    .txe_n(txe_n), .tend_n(tend_n), .rxf_n(rxf_n), .stk_n(stk_n),
    .ie(ie), .req_q(req_q), .cpu_q(cpu_irq)
  );

  assign flag_stop = stk_q[STK_STOP];
  assign flag_nack = stk_q[STK_NACK];
  assign flag_al   = stk_q[STK_AL];
  assign irq_txe   = req_q[REQ_TXE];
  assign irq_tend  = req_q[REQ_TEND];
  assign irq_rxf   = req_q[REQ_RXF];
  assign irq_stop  = req_q[REQ_STOP];
  assign irq_nak   = req_q[REQ_NAK];
endmodule

// File: rtl/serif_irq_unit_chk.sv
module serif_irq_unit_chk (
  input logic clk,
  input logic rst,
  input logic mode_i2c,
  input logic irq_mask,
  input logic tx_wr,
  input logic rx_rd,
  input logic ev_load,
  input logic ev_rxbyte,
  input logic flag_txe,
  input logic flag_rxf,
  input logic flag_al,
  input logic irq_stop,
  input logic cpu_irq
);
  AST_LOAD_SETS_TXE: assert property (@(posedge clk) disable iff (rst)
    ev_load |=> flag_txe); // R2
  AST_WR_CLEARS_TXE: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && !ev_load) |=> !flag_txe); // R2
  AST_RD_CLEARS_RXF: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && !ev_rxbyte) |=> !flag_rxf); // R4
  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!mode_i2c && ev_rxbyte && flag_rxf && !rx_rd) |=> (flag_al && flag_rxf)); // R5
  AST_STOP_SYNC_QUIET: assert property (@(posedge clk) disable iff (rst)
    !mode_i2c |=> !irq_stop); // R9
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    irq_mask |=> !cpu_irq); // R10
endmodule

bind serif_irq_unit serif_irq_unit_chk u_chk (
  .clk(clk), .rst(rst), .mode_i2c(mode_i2c), .irq_mask(irq_mask),
  .tx_wr(tx_wr), .rx_rd(rx_rd), .ev_load(ev_load), .ev_rxbyte(ev_rxbyte),
  .flag_txe(flag_txe), .flag_rxf(flag_rxf), .flag_al(flag_al),
  .irq_stop(irq_stop), .cpu_irq(cpu_irq)
);

// File: tb/serif_irq_unit_bench.sv
module serif_irq_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_i2c = 1'b1, ie_txe = 0, ie_tend = 0, ie_rxf = 0, ie_stop = 0, ie_nak = 0;
  logic irq_mask = 0, tx_wr = 0, rx_rd = 0, stat_rd = 0, clr_stop = 0, clr_nack = 0, clr_al = 0;
  logic ev_load = 0, ev_txdone = 0, ev_rxbyte = 0, ev_stop = 0, ev_nack = 0, ev_al = 0;
  logic flag_txe, flag_tend, flag_rxf, flag_stop, flag_nack, flag_al;
  logic irq_txe, irq_tend, irq_rxf, irq_stop, irq_nak, cpu_irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic m_txe, m_tend, m_rxf, m_stop, m_nack, m_al;
  logic a_stop, a_nack, a_al;
  logic m_itxe, m_itend, m_irxf, m_istop, m_inak, m_cpu;

  always #5 clk = ~clk;

  serif_irq_unit u_serif_irq_unit (.*);

  task automatic chk(input string req, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_txe = 1; m_tend = 0; m_rxf = 0; m_stop = 0; m_nack = 0; m_al = 0;
    a_stop = 0; a_nack = 0; a_al = 0;
    m_itxe = 0; m_itend = 0; m_irxf = 0; m_istop = 0; m_inak = 0; m_cpu = 0;
  endtask

  // next state from the inputs presently driven
  task automatic model_step();
    logic n_txe, n_tend, n_rxf, ovr, s_stop, s_nack, s_al;
    n_txe  = ev_load ? 1'b1 : (tx_wr ? 1'b0 : m_txe);                 // R2
    n_tend = (ev_txdone && m_txe) ? 1'b1 : (tx_wr ? 1'b0 : m_tend);   // R3
    n_rxf  = ev_rxbyte ? 1'b1 : (rx_rd ? 1'b0 : m_rxf);               // R4
    ovr    = !mode_i2c && ev_rxbyte && m_rxf && !rx_rd;               // R5
    s_stop = ev_stop && mode_i2c;                                     // R9
    s_nack = ev_nack && mode_i2c;
    s_al   = ev_al || ovr;
    // R6 read-then-clear
    a_stop = (stat_rd && m_stop) || (a_stop && !clr_stop) ? 1'b1 : 1'b0;
    a_nack = (stat_rd && m_nack) || (a_nack && !clr_nack) ? 1'b1 : 1'b0;
    a_al   = (stat_rd && m_al)   || (a_al   && !clr_al)   ? 1'b1 : 1'b0;
    m_txe = n_txe; m_tend = n_tend; m_rxf = n_rxf;
    m_stop = s_stop;
    m_nack = s_nack;
    m_al   = s_al;
    m_itxe  = m_txe & ie_txe;                                         // R7
    m_itend = m_tend & ie_tend;
    m_irxf  = m_rxf & ie_rxf;
    m_istop = m_stop & ie_stop & mode_i2c;                            // R9
    m_inak  = ie_nak & (m_al | (m_nack & mode_i2c));                  // R8
    m_cpu   = (m_itxe | m_itend | m_irxf | m_istop | m_inak) & ~irq_mask; // R10
  endtask

  logic p_stop, p_nack, p_al, p_as, p_an, p_aa;
  task automatic step();
    // sticky flags need the pre-step arm values, so keep them
    p_stop = m_stop; p_nack = m_nack; p_al = m_al;
    p_as = a_stop; p_an = a_nack; p_aa = a_al;
    model_step();
    m_stop = m_stop | (p_stop & ~(clr_stop & p_as));
    m_nack = m_nack | (p_nack & ~(clr_nack & p_an));
    m_al   = m_al   | (p_al   & ~(clr_al   & p_aa));
    m_istop = m_stop & ie_stop & mode_i2c;
    m_inak  = ie_nak & (m_al | (m_nack & mode_i2c));
    m_cpu   = (m_itxe | m_itend | m_irxf | m_istop | m_inak) & ~irq_mask;
    @(posedge clk);
    #1;
    chk("R2", "flag_txe",  flag_txe,  m_txe);
    chk("R3", "flag_tend", flag_tend, m_tend);
    chk("R4", "flag_rxf",  flag_rxf,  m_rxf);
    chk("R6", "flag_stop", flag_stop, m_stop);
    chk("R9", "flag_nack", flag_nack, m_nack);
    chk("R5", "flag_al",   flag_al,   m_al);
    chk("R7", "irq_txe",   irq_txe,   m_itxe);
    chk("R7", "irq_tend",  irq_tend,  m_itend);
    chk("R7", "irq_rxf",   irq_rxf,   m_irxf);
    chk("R9", "irq_stop",  irq_stop,  m_istop);
    chk("R8", "irq_nak",   irq_nak,   m_inak);
    chk("R10", "cpu_irq",  cpu_irq,   m_cpu);
    @(negedge clk);
  endtask

  task automatic idle();
    tx_wr = 0; rx_rd = 0; stat_rd = 0; clr_stop = 0; clr_nack = 0; clr_al = 0;
    ev_load = 0; ev_txdone = 0; ev_rxbyte = 0; ev_stop = 0; ev_nack = 0; ev_al = 0;
  endtask

  function automatic logic pr(input int n);
    return ($urandom_range(n - 1) == 0);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", "flag_txe",  flag_txe, 1'b1);
    chk("R1", "flag_tend", flag_tend, 1'b0);
    chk("R1", "flag_rxf",  flag_rxf, 1'b0);
    chk("R1", "flag_al",   flag_al, 1'b0);
    chk("R1", "cpu_irq",   cpu_irq, 1'b0);
    chk("R1", "irq_txe",   irq_txe, 1'b0);

    // directed: R6 unarmed clear is ignored
    ie_stop = 1; ie_nak = 1;
    idle(); ev_stop = 1; step();
    idle(); clr_stop = 1; step();
    chk("R6", "flag_stop unarmed clear", flag_stop, 1'b1);
    idle(); stat_rd = 1; step();
    idle(); clr_stop = 1; step();
    chk("R6", "flag_stop armed clear", flag_stop, 1'b0);
    // directed: R5 overrun in sync mode, none in I2C
    mode_i2c = 0;
    idle(); ev_rxbyte = 1; step();
    idle(); ev_rxbyte = 1; step();
    chk("R5", "overrun flag_al", flag_al, 1'b1);
    chk("R5", "overrun keeps rxf", flag_rxf, 1'b1);
    // directed: R2 same-cycle write and load
    idle(); tx_wr = 1; ev_load = 1; step();
    chk("R2", "txe set wins", flag_txe, 1'b1);

    // random sweep over both modes and all enables
    for (int i = 0; i < 12000; i++) begin
      if (i % 400 == 0) mode_i2c = ~mode_i2c;
      if (i % 50 == 0) begin
        ie_txe = pr(2); ie_tend = pr(2); ie_rxf = pr(2); ie_stop = pr(2); ie_nak = pr(2);
      end
      if (i % 13 == 0) irq_mask = pr(3);
      tx_wr = pr(4); rx_rd = pr(4); stat_rd = pr(4);
      clr_stop = pr(4); clr_nack = pr(4); clr_al = pr(4);
      ev_load = pr(4); ev_txdone = pr(3); ev_rxbyte = pr(3);
      ev_stop = pr(8); ev_nack = pr(8); ev_al = pr(12);
      step();
    end

    // reset again mid-run: R1
    idle(); rst = 1; @(posedge clk); #1; rst = 0; model_reset();
    chk("R1", "flag_txe after reset", flag_txe, 1'b1);
    chk("R1", "irq_nak after reset", irq_nak, 1'b0);
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule